// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM that has one shared bidirectional data bus. The host offers a single request (read or write, address, write data) while the controller reports it can take one. The controller then runs the memory strobes through a fixed series of phases, each lasting a whole number of clock cycles. It finishes with a one-clock completion pulse, and for a read it presents the returned byte.

On the memory side the controller drives a pair of chip enables of opposite polarity, an active-low output enable and an active-low write enable, together with the outgoing data and a drive enable for the data-bus tri-state buffer. The phase lengths are parameters in clock cycles. By default they are worked out from the memory's nanosecond limits and the clock period, rounding up. Output enable stays high for the whole of every write. The data-bus drivers switch on only one clock after write enable falls, which gives the memory time to turn its own output off. They switch off in the same clock in which write enable rises.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, `req_ready` is 1, `rsp_done` is 0, `mem_sel_n` is 1, `mem_sel` is 0, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_rdata` is 0.
- R2: `req_ready` is 1 only while the controller is idle. A request is taken only at a clock edge where both `req_ready` and `req_valid` are 1. `req_valid` held high during a transaction has no effect on the strobes until the controller is idle again.
- R3: A read holds `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly T_RD cycles, starting in the cycle after acceptance, with `mem_addr` equal to the accepted address.
- R4: `rsp_rdata` takes the value of `mem_dq_in` present in the last read cycle. It shows that value from the completion cycle onward, and it does not change until the next read completes.
- R5: A write holds the chip selected, `mem_oe_n`=1 and `mem_we_n`=0 for exactly T_WP+1 cycles, starting in the cycle after acceptance, with `mem_addr` equal to the accepted address.
- R6: During a write, `mem_dq_oe` is 0 in the first cycle with `mem_we_n` low and 1 in the remaining T_WP cycles. It returns to 0 in the same cycle in which `mem_we_n` returns to 1. While it is 1, `mem_dq_out` equals the accepted write data.
- R7: After the write pulse, the controller spends T_WR_RECOVER cycles with the chip deselected and both strobes high before it completes.
- R8: `rsp_done` is 1 for exactly one cycle, which is the first idle cycle after a transaction. A request presented in that cycle is accepted at once.
- R9: The chip enable pair always has opposite levels: `mem_sel_n` is 1 exactly when `mem_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Chip enable, active low |
| mem_sel | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for the data-bus buffer |
| mem_dq_in | input | DATA_W | Data read from the memory bus |

## Verification
If the phase state is wrong, the error shows on the strobe pins in the very next cycle: a read or write phase that is one cycle too long or too short, or output enable low while write enable is low. A fault in the phase counter gives a completion pulse one or more cycles early or late. A fault in the drive logic shows at once as `mem_dq_oe` rising in the same cycle that write enable falls. A capture that happens in the wrong cycle returns a byte that has not yet settled, and this is visible on `rsp_rdata` in the completion cycle.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the asynchronous SRAM bus controller.
// Assumes nanosecond figures are positive integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_READ     = 3'd1,
        PH_WR_TURN  = 3'd2,
        PH_WR_DRIVE = 3'd3,
        PH_WR_REC   = 3'd4
    } phase_e;

    typedef struct packed {
        logic ready;
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    // Whole clock cycles needed to cover a time span, rounded up.
    function automatic int cycles_for(input int span_ns, input int clk_ns);
        return (span_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one controller phase.
// Loading N makes "last" rise after N further clocks; "last" is high
// whenever the count is zero. Assumes load values fit in CNT_W bits.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_decode.sv
// Maps the controller phase onto the memory strobes and the host ready flag.
// Pure decode; assumes the phase comes straight from a register.
module sram_strobe_decode
    import sram_ctl_pkg::*;
(
    input  phase_e  phase,
    output strobe_t strb
);

    // One fixed strobe pattern per phase; unknown phases fall back to idle.
    always_comb begin
        strb = '{ready: 1'b1, sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        case (phase)
            PH_READ: begin
                strb.ready = 1'b0;
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
                strb.oe_n  = 1'b0;
            end
            PH_WR_TURN: begin
                strb.ready = 1'b0;
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
                strb.we_n  = 1'b0;
            end
            PH_WR_DRIVE: begin
                strb.ready = 1'b0;
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
                strb.we_n  = 1'b0;
                strb.dq_oe = 1'b1;
            end
            PH_WR_REC: begin
                strb.ready = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
// Host-to-asynchronous-SRAM controller. It takes one request while idle
// and sequences the chip enables, output enable, write enable and the data
// drive enable in phases of whole clock cycles, then pulses rsp_done.
// Assumes the memory's timing is met by the cycle counts; they default to
// the nanosecond limits rounded up to whole clock periods.
module sram_bus_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_NS        = 20,
    parameter int ACCESS_NS     = 15,
    parameter int WE_PULSE_NS   = 10,
    parameter int DATA_SETUP_NS = 8,
    parameter int RECOVER_NS    = 3,
    parameter int T_RD          = cycles_for(ACCESS_NS, CLK_NS),
    parameter int T_WP          = cycles_for(max2(WE_PULSE_NS, DATA_SETUP_NS), CLK_NS),
    parameter int T_WR_RECOVER  = cycles_for(RECOVER_NS, CLK_NS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int MAX_CYC = max2(T_RD, max2(T_WP, T_WR_RECOVER));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(T_RD - 1);
    localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(T_WP - 1);
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(T_WR_RECOVER - 1);

    // Zero-length phases are rejected at elaboration.
    if (T_RD < 1) begin : g_bad_rd
        $error("T_RD must be at least 1");
    end
    if (T_WP < 1) begin : g_bad_wp
        $error("T_WP must be at least 1");
    end
    if (T_WR_RECOVER < 1) begin : g_bad_rec
        $error("T_WR_RECOVER must be at least 1");
    end

    phase_e            phase_q, phase_d;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              last;
    logic              capture;
    logic              done_d;
    logic              done_q;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    strobe_t           strb;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    sram_strobe_decode u_decode (
        .phase (phase_q),
        .strb  (strb)
    );

    assign accept = (phase_q == PH_IDLE) && req_valid;

    // Next phase, timer load and capture decisions.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        done_d   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    load = 1'b1;
                    if (req_write) begin
                        phase_d = PH_WR_TURN;
                    end else begin
                        phase_d  = PH_READ;
                        load_val = RD_LOAD;
                    end
                end
            end
            PH_READ: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    capture = 1'b1;
                    done_d  = 1'b1;
                end
            end
            PH_WR_TURN: begin
                phase_d  = PH_WR_DRIVE;
                load     = 1'b1;
                load_val = WP_LOAD;
            end
            PH_WR_DRIVE: begin
                if (last) begin
                    phase_d  = PH_WR_REC;
                    load     = 1'b1;
                    load_val = REC_LOAD;
                end
            end
            PH_WR_REC: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register, completion pulse and request/response holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            phase_q <= phase_d;
            done_q  <= done_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign req_ready  = strb.ready;
    assign rsp_done   = done_q;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_sel_n  = strb.sel_n;
    assign mem_sel    = strb.sel;
    assign mem_oe_n   = strb.oe_n;
    assign mem_we_n   = strb.we_n;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = strb.dq_oe;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker for sram_bus_ctrl, attached to every instance by bind.
// Watches only the top-level ports.
module sram_bus_ctrl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    // R9: the enable pair never shows the same level.
    a_r9_enable_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel);

    // R5: output enable stays off whenever write enable is low.
    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R6: the bus is driven only after write enable has been low for a cycle.
    a_r6_drive_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !$past(mem_we_n)));

    // R6: the drivers are off in the cycle write enable rises.
    a_r6_release_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    // R8: completion lasts one clock.
    a_r8_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2: ready only with the memory fully idle.
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3: address stays put while the chip remains selected.
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    // R4: read data changes only as a read completes.
    a_r4_rdata_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_done);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bus_ctrl_tb_top.sv
// Bench: behavioural SRAM plus a queue-based cycle model compared every clock.
module sram_bus_ctrl_tb_top;

    localparam int T_RD = 3;
    localparam int T_WP = 2;
    localparam int T_WR_RECOVER = 2;

    // Control vector order: {ready, done, sel_n, sel, oe_n, we_n, dq_oe}
    localparam logic [6:0] C_IDLE  = 7'b1010110;
    localparam logic [6:0] C_DONE  = 7'b1110110;
    localparam logic [6:0] C_READ  = 7'b0001010;
    localparam logic [6:0] C_WTURN = 7'b0001100;
    localparam logic [6:0] C_WDRV  = 7'b0001101;
    localparam logic [6:0] C_WREC  = 7'b0010110;

    typedef struct {
        logic [6:0]  ctl;
        logic [12:0] addr;
        logic [7:0]  data;
        bit          rd_done;
        string       tag;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [12:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int checks = 0;
    int errors = 0;

    ent_t        q[$];
    logic [7:0]  exp_mem[int];
    logic [7:0]  ram[int];
    bit          cur_ready;
    bit          took;
    bit          have_rd = 0;
    logic [7:0]  last_rd;
    int          rd_age = 0;

    always #10 clk = ~clk;

    sram_bus_ctrl #(.T_RD(T_RD), .T_WP(T_WP), .T_WR_RECOVER(T_WR_RECOVER)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    function automatic logic [7:0] fill(input logic [12:0] a);
        return a[7:0] ^ a[12:5] ^ 8'h5A;
    endfunction

    // Behavioural RAM: data valid only after T_RD read cycles; writes take the driven byte.
    always @(negedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) begin
            rd_age = rd_age + 1;
            if (rd_age >= T_RD)
                mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : fill(mem_addr);
            else
                mem_dq_in = 8'hEE;
        end else begin
            rd_age = 0;
            mem_dq_in = 8'hEE;
        end
        if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe)
            ram[int'(mem_addr)] = mem_dq_out;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_txn(input bit w, input logic [12:0] a, input logic [7:0] d);
        logic [7:0] v;
        if (w) begin
            exp_mem[int'(a)] = d;
            q.push_back('{C_WTURN, a, d, 1'b0, "R5"});
            for (int i = 0; i < T_WP; i++) q.push_back('{C_WDRV, a, d, 1'b0, "R6"});
            for (int i = 0; i < T_WR_RECOVER; i++) q.push_back('{C_WREC, a, d, 1'b0, "R7"});
            q.push_back('{C_DONE, a, d, 1'b0, "R8"});
        end else begin
            v = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : fill(a);
            for (int i = 0; i < T_RD; i++) q.push_back('{C_READ, a, v, 1'b0, "R3"});
            q.push_back('{C_DONE, a, v, 1'b1, "R4"});
        end
    endtask

    // One clock: record acceptance, then compare all outputs with the model.
    task automatic step();
        ent_t e;
        logic [6:0] act;
        took = 0;
        if (cur_ready && req_valid) begin
            push_txn(req_write, req_addr, req_wdata);
            took = 1;
        end
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else e = '{C_IDLE, 13'd0, 8'd0, 1'b0, "R2"};
        act = {req_ready, rsp_done, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe};
        check(act == e.ctl, e.tag, "strobes", int'(act), int'(e.ctl));
        check(mem_sel_n != mem_sel, "R9", "enable pair", int'({mem_sel_n, mem_sel}), 2);
        if (!e.ctl[4]) check(mem_addr == e.addr, e.tag, "address", int'(mem_addr), int'(e.addr));
        if (e.ctl[0]) check(mem_dq_out == e.data, "R6", "write data", int'(mem_dq_out), int'(e.data));
        if (e.rd_done) begin
            have_rd = 1;
            last_rd = e.data;
        end
        if (have_rd) check(rsp_rdata == last_rd, "R4", "read data", int'(rsp_rdata), int'(last_rd));
        cur_ready = e.ctl[6];
    endtask

    task automatic op(input bit w, input logic [12:0] a, input logic [7:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        do step(); while (!took);
        req_valid = 0;
    endtask

    task automatic drain();
        req_valid = 0;
        while (q.size() > 0) step();
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        cur_ready = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({req_ready, rsp_done, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe} == C_IDLE,
              "R1", "reset strobes",
              int'({req_ready, rsp_done, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}), int'(C_IDLE));
        check(rsp_rdata == 8'h00, "R1", "reset read data", int'(rsp_rdata), 0);
        rst_n = 1;
        cur_ready = 1;
        step();

        // R5 R6 R7: writes at both address extremes; R3 R4: read back
        op(1, 13'h0000, 8'hA5);
        op(1, 13'h1FFF, 8'h3C);
        op(0, 13'h0000, 8'h00);
        op(0, 13'h1FFF, 8'h00);
        op(0, 13'h0123, 8'h00);
        drain();

        // R2: request held high through a busy write, taken only on completion
        req_valid = 1; req_write = 1; req_addr = 13'h0042; req_wdata = 8'h11;
        step();
        req_addr = 13'h0055; req_wdata = 8'h77;
        for (int i = 0; i < 8; i++) step();
        drain();
        // R8: back-to-back reads accepted in the completion cycle
        op(0, 13'h0042, 8'h00);
        op(0, 13'h0055, 8'h00);
        op(1, 13'h0042, 8'hC3);
        op(0, 13'h0042, 8'h00);
        drain();

        // Mixed random traffic over a few reused addresses
        for (int i = 0; i < 300; i++) begin
            req_valid = ($urandom % 3) != 0;
            req_write = $urandom % 2;
            req_addr  = 13'($urandom % 16);
            req_wdata = 8'($urandom);
            step();
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule